// File: doc/BRIEF.md
# Pin Interrupt Detect and Aggregation

This block watches a bank of already-filtered input levels and turns them into per-pin sticky status bits and one shared interrupt line. Each pin has its own configuration: a trigger-type bit choosing edge or level sensing, a two-bit polarity code, an interrupt enable, an interrupt mask, and three wake enables, one for each sleep depth. A detected event sets the pin's interrupt status when the pin is enabled, and sets its wake status when the wake enable for the current sleep depth is set.

Pending pins that are visible (interrupt status with the mask open, or any wake status) are folded into a summary vector with one bit per group of four consecutive pins. Software finds work through the summary, clears a pin with write-1-to-clear strobes, and then pulses end-of-interrupt, which drops the shared line for one cycle so that a still-pending source produces a fresh assertion.

Configuration is changed through single-cycle operations addressed to one pin: set trigger, enable, disable, mask, unmask and set wake enables.

Top module: `gpio_irq_agg`

## Requirements
- R1: With the trigger bit at 0 (edge), polarity code 00 detects a falling edge, 01 a rising edge, 10 both edges, and 11 nothing; the status bit is set on the clock edge that first samples the new level.
- R2: With the trigger bit at 1 (level), code 00 is active while the level is low and 01 while it is high; codes 10 and 11 detect nothing; a status cleared while the level stays active is set again on the following clock edge.
- R3: Interrupt status is captured only while the pin is enabled; the enable operation (code 2) sets enable and mask-open, disable (code 3) clears both, mask (code 4) closes only the mask, unmask (code 5) reopens it.
- R4: A closed mask does not stop interrupt status from being captured; it only keeps that status out of the summary and the shared line.
- R5: Sleep depth 1, 2 or 3 selects wake-enable bit 0, 1 or 2; at depth 0 no wake status is set; wake status is independent of interrupt enable and mask and always reaches the summary.
- R6: The clear strobe with the interrupt flag clears the pin's interrupt status, with the wake flag clears its wake status; a clear wins over an event in the same cycle.
- R7: A set-trigger operation (code 1) loads trigger bit and polarity code and clears both status bits of that pin.
- R8: Summary bit g is the OR of the visible pending state of pins 4g to 4g+3.
- R9: The shared line is a register that is high one cycle after the summary is non-zero; an end-of-interrupt pulse forces it low on the next cycle, after which it follows the summary again.
- R10: After reset all configuration, all status bits, the summary and the shared line are zero, and no edge is detected in the first cycle out of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_lvl | input | NUM_PINS | Filtered pin levels |
| sleep_lvl | input | 2 | Current sleep depth, 0 = awake |
| cfg_op | input | 3 | Configuration operation code, 0 = none |
| cfg_pin | input | PIN_AW | Pin addressed by the operation |
| cfg_trig_level | input | 1 | Trigger bit for set-trigger |
| cfg_act | input | 2 | Polarity code for set-trigger |
| cfg_wake | input | 3 | Wake enables for set-wake (code 6) |
| clr_we | input | 1 | Clear strobe |
| clr_pin | input | PIN_AW | Pin addressed by the clear |
| clr_int | input | 1 | Clear interrupt status flag |
| clr_wake | input | 1 | Clear wake status flag |
| eoi | input | 1 | End-of-interrupt pulse |
| int_sts | output | NUM_PINS | Per-pin interrupt status |
| wake_sts | output | NUM_PINS | Per-pin wake status |
| summary | output | NUM_GRP | Group pending summary |
| irq | output | 1 | Shared interrupt line |

## Verification
Detection is tried over a table that pairs each trigger type and polarity code with a before/after level pair, so a rising edge, a falling edge, a held level and the reserved codes each give a distinct expected status. Directed sequences then separate capture from visibility (masked but captured, disabled and not captured), wake capture at a matching versus non-matching sleep depth, the clear-versus-active-level race in level mode, and the one-cycle drop and re-assertion of the shared line around end-of-interrupt.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_TRIG    = 3'd1,
    OP_ENABLE  = 3'd2,
    OP_DISABLE = 3'd3,
    OP_MASK    = 3'd4,
    OP_UNMASK  = 3'd5,
    OP_WAKE    = 3'd6
  } cfg_op_e;

  localparam logic [1:0] POL_LOW  = 2'b00;
  localparam logic [1:0] POL_HIGH = 2'b01;
  localparam logic [1:0] POL_BOTH = 2'b10;

  typedef struct packed {
    logic       trig_level;
    logic [1:0] pol;
    logic       en;
    logic       mask_open;
    logic [2:0] wake_en;
  } pin_cfg_t;

  // Event decision from current level, previous level and configuration.
  function automatic logic pin_event(input logic trig_level, input logic [1:0] pol,
                                     input logic lvl, input logic prev);
    logic rise;
    logic fall;
    rise = lvl & ~prev;
    fall = ~lvl & prev;
    if (trig_level) begin
      case (pol)
        POL_LOW:  return ~lvl;
        POL_HIGH: return lvl;
        default:  return 1'b0;
      endcase
    end else begin
      case (pol)
        POL_LOW:  return fall;
        POL_HIGH: return rise;
        POL_BOTH: return rise | fall;
        default:  return 1'b0;
      endcase
    end
  endfunction

  // Wake enable that applies at the given sleep depth.
  function automatic logic wake_select(input logic [2:0] wake_en, input logic [1:0] depth);
    case (depth)
      2'd1:    return wake_en[0];
      2'd2:    return wake_en[1];
      2'd3:    return wake_en[2];
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  cfg_op_e    op,
  input  logic       trig_level,
  input  logic [1:0] pol,
  input  logic [2:0] wake,
  output pin_cfg_t   cfg,
  output logic       trig_wr
);

  pin_cfg_t cfg_q;

  assign trig_wr = sel && (op == OP_TRIG);
  assign cfg     = cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (sel) begin
      case (op)
        OP_TRIG: begin
          cfg_q.trig_level <= trig_level;
          cfg_q.pol        <= pol;
        end
        OP_ENABLE: begin
          cfg_q.en        <= 1'b1;
          cfg_q.mask_open <= 1'b1;
        end
        OP_DISABLE: begin
          cfg_q.en        <= 1'b0;
          cfg_q.mask_open <= 1'b0;
        end
        OP_MASK:   cfg_q.mask_open <= 1'b0;
        OP_UNMASK: cfg_q.mask_open <= 1'b1;
        OP_WAKE:   cfg_q.wake_en   <= wake;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_pin.sv
module gpio_irq_pin
  import gpio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       armed,
  input  logic       lvl,
  input  logic [1:0] sleep_lvl,
  input  pin_cfg_t   cfg,
  input  logic       trig_wr,
  input  logic       clr_int,
  input  logic       clr_wake,
  output logic       evt,
  output logic       int_sts,
  output logic       wake_sts
);

  logic prev_q;
  logic int_q;
  logic wake_q;
  logic int_hit;
  logic wake_hit;

  assign evt      = armed & pin_event(cfg.trig_level, cfg.pol, lvl, prev_q);
  assign int_hit  = evt & cfg.en;
  assign wake_hit = evt & wake_select(cfg.wake_en, sleep_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      int_q  <= 1'b0;
      wake_q <= 1'b0;
    end else begin
      prev_q <= lvl;
      if (trig_wr || clr_int)  int_q <= 1'b0;
      else if (int_hit)        int_q <= 1'b1;
      if (trig_wr || clr_wake) wake_q <= 1'b0;
      else if (wake_hit)       wake_q <= 1'b1;
    end
  end

  assign int_sts  = int_q;
  assign wake_sts = wake_q;

endmodule

// File: rtl/gpio_irq_summary.sv
module gpio_irq_summary #(
  parameter int NUM_PINS  = 16,
  parameter int GRP_PINS  = 4,
  localparam int NUM_GRP  = (NUM_PINS + GRP_PINS - 1) / GRP_PINS,
  localparam int PAD_PINS = NUM_GRP * GRP_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] visible,
  input  logic                eoi,
  output logic [NUM_GRP-1:0]  summary,
  output logic                irq
);

  logic [PAD_PINS-1:0] vis_pad;
  logic                irq_q;

  assign vis_pad = PAD_PINS'(visible);

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign summary[g] = |vis_pad[g*GRP_PINS +: GRP_PINS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq_q <= 1'b0;
    else if (eoi) irq_q <= 1'b0;
    else          irq_q <= |summary;
  end

  assign irq = irq_q;

endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int GRP_PINS = 4,
  localparam int PIN_AW  = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1,
  localparam int NUM_GRP = (NUM_PINS + GRP_PINS - 1) / GRP_PINS
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_lvl,
  input  logic [1:0]          sleep_lvl,
  input  logic [2:0]          cfg_op,
  input  logic [PIN_AW-1:0]   cfg_pin,
  input  logic                cfg_trig_level,
  input  logic [1:0]          cfg_act,
  input  logic [2:0]          cfg_wake,
  input  logic                clr_we,
  input  logic [PIN_AW-1:0]   clr_pin,
  input  logic                clr_int,
  input  logic                clr_wake,
  input  logic                eoi,
  output logic [NUM_PINS-1:0] int_sts,
  output logic [NUM_PINS-1:0] wake_sts,
  output logic [NUM_GRP-1:0]  summary,
  output logic                irq
);

  cfg_op_e             op;
  logic                armed_q;
  logic [NUM_PINS-1:0] pin_en;
  logic [NUM_PINS-1:0] pin_open;
  logic [NUM_PINS-1:0] pin_evt;
  logic [NUM_PINS-1:0] visible;

  assign op = cfg_op_e'(cfg_op);

  // Edge detection is held off for the first cycle after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pin_cfg_t cfg;
    logic     trig_wr;
    logic     cfg_sel;
    logic     clr_sel;

    assign cfg_sel = (cfg_pin == PIN_AW'(p));
    assign clr_sel = clr_we && (clr_pin == PIN_AW'(p));

    gpio_irq_cfg u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (cfg_sel),
      .op         (op),
      .trig_level (cfg_trig_level),
      .pol        (cfg_act),
      .wake       (cfg_wake),
      .cfg        (cfg),
      .trig_wr    (trig_wr)
    );

    gpio_irq_pin u_pin (
      .clk       (clk),
      .rst_n     (rst_n),
      .armed     (armed_q),
      .lvl       (pin_lvl[p]),
      .sleep_lvl (sleep_lvl),
      .cfg       (cfg),
      .trig_wr   (trig_wr),
      .clr_int   (clr_sel && clr_int),
      .clr_wake  (clr_sel && clr_wake),
      .evt       (pin_evt[p]),
      .int_sts   (int_sts[p]),
      .wake_sts  (wake_sts[p])
    );

    assign pin_en[p]   = cfg.en;
    assign pin_open[p] = cfg.mask_open;
    assign visible[p]  = (int_sts[p] & cfg.mask_open) | wake_sts[p];
  end

  gpio_irq_summary #(
    .NUM_PINS (NUM_PINS),
    .GRP_PINS (GRP_PINS)
  ) u_sum (
    .clk     (clk),
    .rst_n   (rst_n),
    .visible (visible),
    .eoi     (eoi),
    .summary (summary),
    .irq     (irq)
  );

endmodule

// File: rtl/gpio_irq_agg_chk.sv
module gpio_irq_agg_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int NUM_GRP  = 4,
  parameter int PIN_AW   = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                eoi,
  input logic [NUM_GRP-1:0]  summary,
  input logic                irq,
  input logic [NUM_PINS-1:0] int_sts,
  input logic [NUM_PINS-1:0] wake_sts,
  input logic [NUM_PINS-1:0] pin_en,
  input logic [2:0]          cfg_op,
  input logic [PIN_AW-1:0]   cfg_pin,
  input logic                clr_we,
  input logic                clr_int,
  input logic [PIN_AW-1:0]   clr_pin
);

  // R9
  eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoi |=> !irq);

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((|summary) && !eoi) |=> irq);

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|summary) |=> !irq);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    // R6
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_we && clr_int && clr_pin == PIN_AW'(p)) |=> !int_sts[p]);

    // R7
    trig_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_op == 3'(OP_TRIG) && cfg_pin == PIN_AW'(p)) |=> (!int_sts[p] && !wake_sts[p]));

    // R3
    no_capture_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_en[p] && !int_sts[p]) |=> !int_sts[p]);
  end

endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(
  .NUM_PINS (NUM_PINS),
  .NUM_GRP  (NUM_GRP),
  .PIN_AW   (PIN_AW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .eoi      (eoi),
  .summary  (summary),
  .irq      (irq),
  .int_sts  (int_sts),
  .wake_sts (wake_sts),
  .pin_en   (pin_en),
  .cfg_op   (cfg_op),
  .cfg_pin  (cfg_pin),
  .clr_we   (clr_we),
  .clr_int  (clr_int),
  .clr_pin  (clr_pin)
);

// File: tb/gpio_irq_agg_tb.sv
`timescale 1ns/1ps
module gpio_irq_agg_tb;

  localparam int N  = 16;
  localparam int AW = 4;
  localparam int G  = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  pin_lvl = '0;
  logic [1:0]    sleep_lvl = '0;
  logic [2:0]    cfg_op = '0;
  logic [AW-1:0] cfg_pin = '0;
  logic          cfg_trig_level = 1'b0;
  logic [1:0]    cfg_act = '0;
  logic [2:0]    cfg_wake = '0;
  logic          clr_we = 1'b0;
  logic [AW-1:0] clr_pin = '0;
  logic          clr_int = 1'b0;
  logic          clr_wake = 1'b0;
  logic          eoi = 1'b0;
  logic [N-1:0]  int_sts;
  logic [N-1:0]  wake_sts;
  logic [G-1:0]  summary;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_irq_agg #(.NUM_PINS(N), .GRP_PINS(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_lvl(pin_lvl), .sleep_lvl(sleep_lvl),
    .cfg_op(cfg_op), .cfg_pin(cfg_pin), .cfg_trig_level(cfg_trig_level),
    .cfg_act(cfg_act), .cfg_wake(cfg_wake), .clr_we(clr_we), .clr_pin(clr_pin),
    .clr_int(clr_int), .clr_wake(clr_wake), .eoi(eoi), .int_sts(int_sts),
    .wake_sts(wake_sts), .summary(summary), .irq(irq)
  );

  // Vector: {trig_level, pol[1:0], level_before, level_after, expected_status}
  localparam logic [5:0] VEC [13] = '{
    6'b0_00_10_1, 6'b0_00_01_0, 6'b0_01_01_1, 6'b0_01_10_0,
    6'b0_10_01_1, 6'b0_10_10_1, 6'b0_10_11_0, 6'b0_11_01_0,
    6'b1_00_10_1, 6'b1_00_11_0, 6'b1_01_01_1, 6'b1_01_10_0,
    6'b1_10_01_0
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input int pin,
                       input logic trig = 1'b0, input logic [1:0] pol = 2'b00,
                       input logic [2:0] wk = 3'b000);
    cfg_op = op; cfg_pin = AW'(pin); cfg_trig_level = trig; cfg_act = pol; cfg_wake = wk;
    tick();
    cfg_op = 3'd0;
  endtask

  task automatic do_clr(input int pin, input logic ci, input logic cw);
    clr_we = 1'b1; clr_pin = AW'(pin); clr_int = ci; clr_wake = cw;
    tick();
    clr_we = 1'b0; clr_int = 1'b0; clr_wake = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
    end
  end

  initial begin
    tick(); tick();
    // R10 reset state
    chk(int_sts, 0, "R10 int_sts");
    chk(wake_sts, 0, "R10 wake_sts");
    chk({summary, irq}, 0, "R10 summary/irq");
    rst_n = 1'b1;
    tick();
    chk({summary, irq}, 0, "R10 after release");

    // R1 / R2 detection table on pin 0
    for (int i = 0; i < 13; i++) begin
      do_op(3'd3, 0);
      pin_lvl[0] = VEC[i][2];
      do_op(3'd1, 0, VEC[i][5], VEC[i][4:3]);
      do_op(3'd2, 0);
      tick();
      do_clr(0, 1'b1, 1'b0);
      pin_lvl[0] = VEC[i][1];
      tick();
      chk(int_sts[0], VEC[i][0], $sformatf("R1/R2 vector %0d", i));
    end
    do_op(3'd3, 0);
    do_clr(0, 1'b1, 1'b0);
    tick(); tick();
    chk({summary, irq}, 0, "R9 idle after table");

    // R3: disabled pin does not capture
    pin_lvl[2] = 1'b0;
    do_op(3'd1, 2, 1'b0, 2'b01);
    pin_lvl[2] = 1'b1; tick();
    chk(int_sts[2], 0, "R3 disabled no capture");
    // R3 / R4: enabled then masked still captures, not visible
    do_op(3'd2, 2);
    do_op(3'd4, 2);
    pin_lvl[2] = 1'b0; tick();
    pin_lvl[2] = 1'b1; tick();
    chk(int_sts[2], 1, "R4 masked capture");
    chk(summary, 0, "R4 masked not in summary");
    tick();
    chk(irq, 0, "R4 masked no irq");
    do_op(3'd3, 2);
    do_clr(2, 1'b1, 1'b0);

    // R8 / R9 / R4: pin 5 lives in group 1
    pin_lvl[5] = 1'b0;
    do_op(3'd1, 5, 1'b0, 2'b01);
    do_op(3'd2, 5);
    do_op(3'd4, 5);
    pin_lvl[5] = 1'b1; tick();
    chk(int_sts[5], 1, "R4 captured while masked");
    do_op(3'd5, 5);
    chk(summary, 4'b0010, "R8 group of pin 5");
    chk(irq, 0, "R9 irq lags summary");
    tick();
    chk(irq, 1, "R9 irq asserted");
    eoi = 1'b1; tick(); eoi = 1'b0;
    chk(irq, 0, "R9 eoi drops line");
    tick();
    chk(irq, 1, "R9 re-assert while pending");
    do_clr(5, 1'b1, 1'b0);
    chk(int_sts[5], 0, "R6 write-1 clear");
    chk(summary, 0, "R8 summary after clear");
    tick();
    chk(irq, 0, "R9 line low after clear");
    do_op(3'd3, 5);

    // R2 / R6: level mode re-assert, clear wins over active level
    pin_lvl[3] = 1'b1;
    do_op(3'd1, 3, 1'b1, 2'b01);
    do_op(3'd2, 3);
    tick();
    chk(int_sts[3], 1, "R2 level high captured");
    do_clr(3, 1'b1, 1'b0);
    chk(int_sts[3], 0, "R6 clear wins over same-cycle event");
    tick();
    chk(int_sts[3], 1, "R2 re-assert after clear");
    pin_lvl[3] = 1'b0;
    do_clr(3, 1'b1, 1'b0);
    tick();
    chk(int_sts[3], 0, "R2 inactive level stays clear");
    do_op(3'd3, 3);

    // R5: wake status on pin 6, both edges, interrupt disabled
    pin_lvl[6] = 1'b0;
    do_op(3'd1, 6, 1'b0, 2'b10);
    do_op(3'd6, 6, 1'b0, 2'b00, 3'b010);
    sleep_lvl = 2'd1;
    pin_lvl[6] = 1'b1; tick();
    chk(wake_sts[6], 0, "R5 depth 1 not enabled");
    sleep_lvl = 2'd2;
    pin_lvl[6] = 1'b0; tick();
    chk(wake_sts[6], 1, "R5 depth 2 wake captured");
    chk(int_sts[6], 0, "R5 interrupt status untouched");
    chk(summary, 4'b0010, "R5 wake visible though masked");
    do_clr(6, 1'b0, 1'b1);
    chk(wake_sts[6], 0, "R6 wake clear");
    sleep_lvl = 2'd0;
    pin_lvl[6] = 1'b1; tick();
    chk(wake_sts[6], 0, "R5 awake no wake");
    sleep_lvl = 2'd2;
    pin_lvl[6] = 1'b0; tick();
    chk(wake_sts[6], 1, "R5 wake again");
    // R7: trigger write clears status
    do_op(3'd1, 6, 1'b0, 2'b11);
    chk(wake_sts[6], 0, "R7 trigger write clears");
    sleep_lvl = 2'd0;

    done = 1;
    finish_run();
  end

endmodule